// File: doc/BRIEF.md
# Asymmetric Programmable Clock Prescaler

This block divides the system clock into a slower clock whose high and low phases are each set on their own. A 5-bit setting gives the number of high cycles and a 3-bit setting gives the number of low cycles. The two phases can therefore differ in width, and a user can keep the duty cycle near one half or skew it as needed. One down counter times both phases. In the high phase the counter is loaded with the high setting and counts down to zero. It then wraps and keeps counting, and the low phase ends when the inverse of its three least significant bits equals the low setting.

Besides the divided clock level, the block gives a one-cycle strobe on each rising and each falling edge. Logic that runs in the system clock domain uses these strobes as enables. An enable input freezes the divider. A legacy prescale select input is accepted so that older register layouts still map onto the block, but it changes nothing.

Top module: `asym_clk_prescaler`

## Requirements
- R1: A synchronous reset drives `div_clk`, `rise_stb` and `fall_stb` low. The first cycle with `en` high after reset starts a high phase.
- R2: Each high phase lasts exactly `hi_cycles + 1` system clock cycles, for `hi_cycles` from 0 to 31.
- R3: Each low phase lasts exactly `lo_cycles + 1` system clock cycles, for `lo_cycles` from 0 to 7.
- R4: In steady state the period is `(hi_cycles + 1) + (lo_cycles + 1)` cycles. A high setting of 19 with a low setting of 7 gives 28 cycles, and 7 with 7 gives 16 cycles.
- R5: `rise_stb` is high for exactly the one cycle in which `div_clk` first reads high after a low phase or after reset.
- R6: `fall_stb` is high for exactly the one cycle in which `div_clk` first reads low after a high phase.
- R7: While `en` is low, `div_clk` holds its level, the phase timing does not advance, and neither strobe is asserted.
- R8: Both settings are sampled only when a high phase begins. A change made in the middle of a period leaves the high and low lengths of that period unchanged, and the new values apply from the next high phase.
- R9: `legacy_sel` has no effect on `div_clk` or on either strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the divider when high |
| hi_cycles | input | 5 | High phase length minus one |
| lo_cycles | input | 3 | Low phase length minus one |
| legacy_sel | input | 1 | Legacy prescale select, ignored |
| div_clk | output | 1 | Divided clock level |
| rise_stb | output | 1 | One-cycle strobe on a rising edge of div_clk |
| fall_stb | output | 1 | One-cycle strobe on a falling edge of div_clk |

## Verification
The directed settings 19/7 and 7/7 check the period arithmetic. The extremes 0/0, 31/0 and 0/7 separate an off-by-one in the zero detector from one in the inverted match, because only one phase moves in each case. A change of setting in the middle of a high phase shows whether the settings are sampled at the reload or read live. Random runs then mix enable gaps, reset pulses, setting changes and `legacy_sel` toggling against a cycle-level phase model, which catches strobes that are mistimed or that leak through a freeze.

// File: rtl/asym_presc_pkg.sv
package asym_presc_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_strobe_t;

    function automatic edge_strobe_t no_edge();
        edge_strobe_t s;
        s.rise = 1'b0;
        s.fall = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/qp_down_counter.sv
module qp_down_counter #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          is_zero
);
    // Reset value of all ones looks like the last cycle of a low phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '1;
        end else if (en) begin
            if (load) cnt <= load_val;
            else      cnt <= cnt - 1'b1;
        end
    end

    assign is_zero = (cnt == '0);

    // Wrap from zero gives an inverted low field of zero for the low phase.
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !load && is_zero) |=> (cnt == '1));
endmodule

// File: rtl/qp_low_match.sv
module qp_low_match #(
    parameter int LW = 3
) (
    input  logic [LW-1:0] cnt_lo,
    input  logic [LW-1:0] lo_ref,
    output logic          hit
);
    logic [LW-1:0] cnt_inv;
    assign cnt_inv = ~cnt_lo;
    assign hit     = (cnt_inv == lo_ref);
endmodule

// File: rtl/qp_phase_ctrl.sv
module qp_phase_ctrl
    import asym_presc_pkg::*;
#(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          is_zero,
    input  logic          lo_hit,
    input  logic [LW-1:0] lo_set,
    output logic          load,
    output logic [LW-1:0] lo_ref,
    output phase_e        phase,
    output edge_strobe_t  stb
);
    assign load = en && (phase == PH_LOW) && lo_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_LOW;
            lo_ref <= '0;
            stb    <= no_edge();
        end else begin
            stb <= no_edge();
            if (en) begin
                unique case (phase)
                    PH_LOW: if (lo_hit) begin
                        phase    <= PH_HIGH;
                        lo_ref   <= lo_set;
                        stb.rise <= 1'b1;
                    end
                    PH_HIGH: if (is_zero) begin
                        phase    <= PH_LOW;
                        stb.fall <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    p_zero_ends_high_r2: assert property (@(posedge clk) disable iff (rst)
        (en && phase == PH_HIGH && is_zero) |=> (phase == PH_LOW));
    p_match_ends_low_r3: assert property (@(posedge clk) disable iff (rst)
        (en && phase == PH_LOW && lo_hit) |=> (phase == PH_HIGH));
    p_rise_stb_r5: assert property (@(posedge clk) disable iff (rst)
        stb.rise |-> (phase == PH_HIGH && $past(phase) == PH_LOW));
    p_fall_stb_r6: assert property (@(posedge clk) disable iff (rst)
        stb.fall |-> (phase == PH_LOW && $past(phase) == PH_HIGH));
    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(phase) && !stb.rise && !stb.fall));
endmodule

// File: rtl/asym_clk_prescaler.sv
module asym_clk_prescaler
    import asym_presc_pkg::*;
#(
    parameter int HI_W = 5,
    parameter int LO_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [HI_W-1:0] hi_cycles,
    input  logic [LO_W-1:0] lo_cycles,
    input  logic            legacy_sel,
    output logic            div_clk,
    output logic            rise_stb,
    output logic            fall_stb
);
    localparam int CW = HI_W;

    logic [CW-1:0]   cnt;
    logic            is_zero;
    logic            lo_hit;
    logic            load;
    logic [LO_W-1:0] lo_ref;
    phase_e          phase;
    edge_strobe_t    stb;

    // Kept only for register layout compatibility.
    logic unused_legacy;
    assign unused_legacy = legacy_sel;

    qp_down_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .load(load),
        .load_val(hi_cycles), .cnt(cnt), .is_zero(is_zero)
    );

    qp_low_match #(.LW(LO_W)) u_match (
        .cnt_lo(cnt[LO_W-1:0]), .lo_ref(lo_ref), .hit(lo_hit)
    );

    qp_phase_ctrl #(.LW(LO_W)) u_ctrl (
        .clk(clk), .rst(rst), .en(en), .is_zero(is_zero), .lo_hit(lo_hit),
        .lo_set(lo_cycles), .load(load), .lo_ref(lo_ref),
        .phase(phase), .stb(stb)
    );

    assign div_clk  = (phase == PH_HIGH);
    assign rise_stb = stb.rise;
    assign fall_stb = stb.fall;

    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> (!div_clk && !rise_stb && !fall_stb));
endmodule

// File: tb/asym_clk_prescaler_tb_top.sv
module asym_clk_prescaler_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [4:0] hi_set = '0;
    logic [2:0] lo_set = '0;
    logic       legacy = 1'b0;
    logic       div_clk, rise_stb, fall_stb;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // phase model state
    bit m_lvl = 1'b0;
    int m_left = 0;
    bit m_rise = 1'b0;
    bit m_fall = 1'b0;
    int m_lq = 0;
    bit pr_rst, pr_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    asym_clk_prescaler dut_i (
        .clk(clk), .rst(rst), .en(en), .hi_cycles(hi_set), .lo_cycles(lo_set),
        .legacy_sel(legacy), .div_clk(div_clk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    function void model_step();
        pr_rst = rst;
        pr_en  = en;
        m_rise = 1'b0;
        m_fall = 1'b0;
        if (rst) begin
            m_lvl  = 1'b0;
            m_left = 0;
        end else if (en) begin
            if (m_left == 0) begin
                if (!m_lvl) begin
                    m_lvl = 1'b1; m_left = int'(hi_set); m_lq = int'(lo_set); m_rise = 1'b1;
                end else begin
                    m_lvl = 1'b0; m_left = m_lq; m_fall = 1'b1;
                end
            end else begin
                m_left = m_left - 1;
            end
        end
    endfunction

    task automatic check_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        string tl, tr, tf;
        model_step();
        @(posedge clk);
        #1;
        tl = pr_rst ? "R1 level" : (!pr_en ? "R7 level" : (m_lvl ? "R2 level" : "R3 level"));
        tr = pr_rst ? "R1 rise"  : (!pr_en ? "R7 rise"  : "R5 rise");
        tf = pr_rst ? "R1 fall"  : (!pr_en ? "R7 fall"  : "R6 fall");
        check_val(tl, int'(div_clk), int'(m_lvl));
        check_val(tr, int'(rise_stb), int'(m_rise));
        check_val(tf, int'(fall_stb), int'(m_fall));
    endtask

    task automatic wait_rise();
        for (int i = 0; i < 200; i++) begin
            tick();
            if (rise_stb) return;
        end
        check_val("R5 rise timeout", 0, 1);
    endtask

    // Count high and low cycles of the period starting at the current rise.
    task automatic measure(output int nh, output int nl);
        nh = 0; nl = 0;
        for (int i = 0; i < 64; i++) begin
            nh++; tick();
            if (fall_stb) break;
        end
        for (int i = 0; i < 64; i++) begin
            nl++; tick();
            if (rise_stb) break;
        end
    endtask

    task automatic directed(int h, int l, string tag);
        int nh, nl;
        hi_set = 5'(h); lo_set = 3'(l);
        wait_rise();
        wait_rise();
        measure(nh, nl);
        check_val({"R2 high ", tag}, nh, h + 1);
        check_val({"R3 low ", tag}, nl, l + 1);
        check_val({"R4 period ", tag}, nh + nl, h + l + 2);
    endtask

    initial begin
        int nh, nl;
        bit lvl0;
        void'($urandom(32'd20240611));
        rst = 1'b1; en = 1'b1;
        repeat (3) tick();
        check_val("R1 reset level", int'(div_clk), 0);
        rst = 1'b0;
        tick();
        check_val("R1 first enabled level", int'(div_clk), 1);
        check_val("R1 first enabled rise", int'(rise_stb), 1);

        directed(19, 7, "19/7");
        directed(7, 7, "7/7");
        directed(0, 0, "0/0");
        directed(31, 0, "31/0");
        directed(0, 7, "0/7");
        directed(3, 5, "3/5");

        // R8: change settings mid high phase
        hi_set = 5'd19; lo_set = 3'd7;
        wait_rise(); wait_rise();
        repeat (3) tick();
        hi_set = 5'd2; lo_set = 3'd1;
        nh = 4; nl = 0;
        for (int i = 0; i < 64; i++) begin
            tick();
            if (fall_stb) break;
            nh++;
        end
        for (int i = 0; i < 64; i++) begin
            nl++; tick();
            if (rise_stb) break;
        end
        check_val("R8 old high kept", nh, 20);
        check_val("R8 old low kept", nl, 8);
        measure(nh, nl);
        check_val("R8 new high", nh, 3);
        check_val("R8 new low", nl, 2);

        // R7: freeze in the middle of a high phase
        hi_set = 5'd10; lo_set = 3'd4;
        wait_rise(); wait_rise();
        tick(); tick();
        en = 1'b0;
        lvl0 = div_clk;
        for (int i = 0; i < 10; i++) begin
            tick();
            check_val("R7 frozen level", int'(div_clk), int'(lvl0));
            check_val("R7 no strobe", int'(rise_stb | fall_stb), 0);
        end
        en = 1'b1;
        nh = 3;
        for (int i = 0; i < 64; i++) begin
            tick();
            if (fall_stb) break;
            nh++;
        end
        check_val("R7 high resumes count", nh, 11);

        // R9: legacy bit toggling
        hi_set = 5'd6; lo_set = 3'd2;
        wait_rise(); wait_rise();
        nh = 0; nl = 0;
        for (int i = 0; i < 64; i++) begin
            legacy = ~legacy; nh++; tick();
            if (fall_stb) break;
        end
        for (int i = 0; i < 64; i++) begin
            legacy = ~legacy; nl++; tick();
            if (rise_stb) break;
        end
        check_val("R9 high with legacy toggling", nh, 7);
        check_val("R9 low with legacy toggling", nl, 3);

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            en = ($urandom % 8) != 0;
            legacy = 1'($urandom);
            rst = ($urandom % 600) == 0;
            if (($urandom % 40) == 0) hi_set = 5'($urandom);
            if (($urandom % 40) == 0) lo_set = 3'($urandom);
            tick();
        end
        rst = 1'b0;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule